// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a down-counting timer that sits beside a pending-interrupt tracker. It runs from the bus clock through a programmable prescaler. Software programs it with three register writes: a start value, a divide setting, and a timer entry. The timer entry holds an interrupt vector, a mask bit and a periodic-mode bit. When the count runs out, the block sends a one-cycle request that carries the programmed vector toward the tracker.

If the entry is masked, or the tracker reports that the timer vector is still outstanding, the block raises no request. It adds one to a saturating counter of missed expiries instead. In one-shot mode the count stops at zero. In periodic mode it reloads from the start value and carries on. The live count is always visible on an output.

Register selection, bus decoding and the tracker itself sit outside the block. The block sees one write strobe, a two-bit register select and a 32-bit data word. The select codes are 0 for start value, 1 for divide setting, 2 for timer entry and 3 for current count.

Top module: `lit_timer`

## Requirements
- R1: After reset, `cur_count`, `tmr_entry`, `miss_count` and `err_status` are zero, `irq_req` is low, and the divide code is 0.
- R2: A divide-setting write takes a 3-bit code from data bits {3,1,0}. Bit 3 is the most significant. Code c from 0 to 6 divides by 2^(c+1), and code 7 divides by 1. Bit 2 and the upper bits have no effect. After a start-value write of N (N nonzero), the first expiry happens N*divisor clock edges after the write edge.
- R3: A start-value write (select 0) of a nonzero N sets `cur_count` to N on the write edge. It cancels any countdown in progress and restarts the prescaler, so the next expiry is timed from this write alone.
- R4: In periodic mode (entry bit 17 = 1), expiry reloads `cur_count` with the start value. Further expiries then follow every N*divisor edges.
- R5: In one-shot mode (entry bit 17 = 0), expiry leaves `cur_count` at zero and no further expiry occurs.
- R6: An expiry with entry bit 16 (mask) = 0 and `vec_pending` low drives `irq_req` high for one cycle, in the cycle after the expiry edge. In that cycle `irq_vector` equals entry bits [7:0].
- R7: An expiry with the mask set or `vec_pending` high raises no request. It adds one to `miss_count`, which saturates at its all-ones value.
- R8: A timer-entry write (select 2) stores the data ANDed with 0x000310FF. Those bits are the vector in [7:0], delivery status in [12], mask in [16] and periodic in [17].
- R9: While `sw_disable` is high, a timer-entry write always stores mask bit 16 as 1.
- R10: A timer-entry write whose vector field is below 16 sets `err_status` bit 6 (value 0x40). The bit then stays set until reset.
- R11: A start-value write of zero stops the timer with `cur_count` = 0, and no request or miss follows.
- R12: A write with select 3 (current count) changes nothing: `cur_count` and `irq_req` are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 start value, 1 divide, 2 entry, 3 current count |
| wr_data | input | 32 | Write data |
| sw_disable | input | 1 | Unit software-disabled; forces mask on entry writes |
| vec_pending | input | 1 | Tracker reports the timer vector still pending |
| cur_count | output | CNT_W | Live count value |
| tmr_entry | output | 32 | Stored timer entry |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |
| miss_count | output | MISS_W | Saturating count of suppressed expiries |
| err_status | output | 8 | Sticky error flags; bit 6 is the illegal-vector flag |

## Verification
The checker watches several rules on every clock cycle:
- A start-value write loads the count.
- A stopped count stays at zero until the next start-value write.
- A request only follows a cycle in which the entry was unmasked and the vector was not pending.
- The miss counter only ever holds still or steps by one, and it stays at its maximum once there.
- A disabled unit always stores the mask bit on entry writes.

Only the bench scenarios can show the rest:
- The exact expiry cycle for each divide code.
- Reload in periodic mode and the silence after a one-shot expiry.
- The restart of timing on a second start-value write.
- Saturation after hundreds of suppressed expiries.
- The entry write mask and the illegal-vector flag.

// File: rtl/lit_pkg.sv
package lit_pkg;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 7;
  localparam logic [DATA_W-1:0] ENTRY_WMASK = 32'h0003_10FF;
  localparam int ENTRY_MASK_BIT = 16;
  localparam int ENTRY_PER_BIT  = 17;
  localparam int ERR_BADVEC_BIT = 6;

  typedef enum logic [1:0] {
    SEL_INIT  = 2'd0,
    SEL_DIV   = 2'd1,
    SEL_ENTRY = 2'd2,
    SEL_CUR   = 2'd3
  } wsel_e;

  // terminal value of the prescaler for a 3-bit divide code
  function automatic logic [PRE_W:0] div_limit(input logic [2:0] code);
    if (code == 3'd7) return '0;
    return ((PRE_W+1)'(2) << code) - (PRE_W+1)'(1);
  endfunction
endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler
  import lit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [2:0] div_code,
  output logic       step
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic [PRE_W:0]   lim;

  always_comb begin
    lim  = div_limit(div_code);
    step = run && ({1'b0, cnt_q} >= lim);
    if (restart || !run || step) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lit_counter.sv
module lit_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             periodic,
  output logic [CNT_W-1:0] cur,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cur_q, cur_d, init_q, init_d;
  logic             run_q, run_d;

  always_comb begin
    cur_d  = cur_q;
    init_d = init_q;
    run_d  = run_q;
    expire = run_q && step && (cur_q == CNT_W'(1));
    if (load) begin
      init_d = load_val;
      cur_d  = load_val;
      run_d  = (load_val != '0);
    end else if (run_q && step) begin
      if (expire) begin
        if (periodic) cur_d = init_q;
        else begin
          cur_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cur_d = cur_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      init_q <= '0;
      run_q  <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      init_q <= init_d;
      run_q  <= run_d;
    end
  end

  assign cur     = cur_q;
  assign running = run_q;
endmodule

// File: rtl/lit_regs.sv
module lit_regs
  import lit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sw_disable,
  output logic [DATA_W-1:0] entry,
  output logic [2:0]        div_code,
  output logic [7:0]        err,
  output logic              init_wr,
  output logic              div_wr
);
  logic [DATA_W-1:0] entry_q, entry_d;
  logic [2:0]        div_q, div_d;
  logic [7:0]        err_q, err_d;
  logic              entry_wr;

  always_comb begin
    init_wr  = wr_en && (wr_sel == SEL_INIT);
    div_wr   = wr_en && (wr_sel == SEL_DIV);
    entry_wr = wr_en && (wr_sel == SEL_ENTRY);
    entry_d  = entry_q;
    div_d    = div_q;
    err_d    = err_q;
    if (entry_wr) begin
      entry_d = wr_data & ENTRY_WMASK;
      if (sw_disable) entry_d[ENTRY_MASK_BIT] = 1'b1;
      if (wr_data[7:0] < 8'd16) err_d[ERR_BADVEC_BIT] = 1'b1;
    end
    if (div_wr) div_d = {wr_data[3], wr_data[1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
      div_q   <= '0;
      err_q   <= '0;
    end else begin
      entry_q <= entry_d;
      div_q   <= div_d;
      err_q   <= err_d;
    end
  end

  assign entry    = entry_q;
  assign div_code = div_q;
  assign err      = err_q;
endmodule

// File: rtl/lit_timer.sv
module lit_timer
  import lit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sw_disable,
  input  logic              vec_pending,
  output logic [CNT_W-1:0]  cur_count,
  output logic [DATA_W-1:0] tmr_entry,
  output logic              irq_req,
  output logic [7:0]        irq_vector,
  output logic [MISS_W-1:0] miss_count,
  output logic [7:0]        err_status
);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic [2:0]        div_code;
  logic              init_wr, div_wr, step, running, expire, fire;
  logic              irq_q, irq_d;
  logic [7:0]        vec_q, vec_d;
  logic [MISS_W-1:0] miss_q, miss_d;

  lit_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sw_disable(sw_disable), .entry(tmr_entry),
    .div_code(div_code), .err(err_status), .init_wr(init_wr), .div_wr(div_wr)
  );

  lit_prescaler pre_i (
    .clk(clk), .rst_n(rst_n), .restart(init_wr || div_wr),
    .run(running), .div_code(div_code), .step(step)
  );

  lit_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(init_wr), .load_val(wr_data[CNT_W-1:0]),
    .step(step), .periodic(tmr_entry[ENTRY_PER_BIT]),
    .cur(cur_count), .running(running), .expire(expire)
  );

  always_comb begin
    fire   = expire && !tmr_entry[ENTRY_MASK_BIT] && !vec_pending;
    irq_d  = fire;
    vec_d  = fire ? tmr_entry[7:0] : vec_q;
    miss_d = miss_q;
    if (expire && !fire && (miss_q != MISS_MAX)) miss_d = miss_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      miss_q <= '0;
    end else begin
      irq_q  <= irq_d;
      vec_q  <= vec_d;
      miss_q <= miss_d;
    end
  end

  assign irq_req    = irq_q;
  assign irq_vector = vec_q;
  assign miss_count = miss_q;
endmodule

// File: rtl/lit_timer_chk.sv
module lit_timer_chk
  import lit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              sw_disable,
  input logic              vec_pending,
  input logic [CNT_W-1:0]  cur_count,
  input logic [DATA_W-1:0] tmr_entry,
  input logic              irq_req,
  input logic [MISS_W-1:0] miss_count
);
  localparam logic [MISS_W-1:0] MAXV = '1;

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_INIT) |=> (cur_count == $past(wr_data[CNT_W-1:0])));

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !(wr_en && wr_sel == SEL_INIT)) |=> (cur_count == '0));

  a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(!tmr_entry[ENTRY_MASK_BIT]) && $past(!vec_pending)));

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == MAXV) |=> (miss_count == MAXV));

  a_r9_force_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_ENTRY && sw_disable) |=> tmr_entry[ENTRY_MASK_BIT]);
endmodule

bind lit_timer lit_timer_chk #(.CNT_W(CNT_W), .MISS_W(MISS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .sw_disable(sw_disable), .vec_pending(vec_pending), .cur_count(cur_count),
  .tmr_entry(tmr_entry), .irq_req(irq_req), .miss_count(miss_count)
);

// File: tb/lit_timer_tb_top.sv
`timescale 1ns/1ps
module lit_timer_tb_top;
  logic        clk, rst_n, wr_en, sw_disable, vec_pending;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data, cur_count, tmr_entry;
  logic        irq_req;
  logic [7:0]  irq_vector, miss_count, err_status;

  int n_chk = 0, n_bad = 0, exp_miss = 0;
  bit done = 0;

  lit_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sw_disable(sw_disable), .vec_pending(vec_pending), .cur_count(cur_count),
    .tmr_entry(tmr_entry), .irq_req(irq_req), .irq_vector(irq_vector),
    .miss_count(miss_count), .err_status(err_status)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: [28:25] divide data, [24:9] start value, [8] periodic, [7:0] vector
  localparam logic [28:0] VTBL [0:4] = '{
    {4'h0, 16'd3, 1'b0, 8'h30},
    {4'h1, 16'd2, 1'b1, 8'h41},
    {4'hB, 16'd5, 1'b0, 8'h52},
    {4'hA, 16'd2, 1'b0, 8'h63},
    {4'h6, 16'd1, 1'b1, 8'h74}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // wait t cycles after a write; request must appear exactly at the last one
  task automatic expect_irq(input int t, input logic [7:0] v, input string req);
    bit early = 0;
    for (int k = 1; k < t; k++) begin
      @(negedge clk);
      if (irq_req) early = 1;
    end
    chk(!early, req, early, 0);
    @(negedge clk);
    chk(irq_req == 1'b1, req, irq_req, 1);
    chk(irq_vector == v, req, irq_vector, v);
  endtask

  task automatic quiet(input int t, input string req);
    bit seen = 0;
    for (int k = 0; k < t; k++) begin
      @(negedge clk);
      if (irq_req) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    sw_disable = 1'b0; vec_pending = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cur_count == 0 && tmr_entry == 0 && !irq_req, "R1", cur_count, 0);
    chk(miss_count == 0 && err_status == 0, "R1", {miss_count, err_status}, 0);
    // R1 default divide code 0 -> divide by 2
    wr(2'd2, 32'h0000_0020);
    wr(2'd0, 32'd2);
    expect_irq(4, 8'h20, "R1");

    // vector table: R2 timing, R5 one-shot, R4 periodic, R6 request
    for (int i = 0; i < 5; i++) begin
      logic [3:0]  dd;
      logic [15:0] n;
      logic        per;
      logic [7:0]  v;
      logic [2:0]  code;
      int          dv, t;
      {dd, n, per, v} = VTBL[i];
      code = {dd[3], dd[1:0]};
      dv   = (code == 3'd7) ? 1 : (2 << code);
      t    = n * dv;
      wr(2'd2, {14'd0, per, 9'd0, v});
      wr(2'd1, {28'd0, dd});
      wr(2'd0, {16'd0, n});
      chk(cur_count == n, "R3", cur_count, n);
      expect_irq(t, v, "R2");
      if (per) begin
        chk(cur_count == n, "R4", cur_count, n);
        expect_irq(t, v, "R4");
        wr(2'd0, 32'd0);
      end else begin
        chk(cur_count == 0, "R5", cur_count, 0);
        quiet(2 * t + 4, "R5");
      end
    end

    // R3 restart cancels the running countdown
    wr(2'd2, 32'h0000_0044);
    wr(2'd1, 32'h0000_000B);
    wr(2'd0, 32'd10);
    repeat (3) @(negedge clk);
    wr(2'd0, 32'd3);
    chk(cur_count == 3, "R3", cur_count, 3);
    expect_irq(3, 8'h44, "R3");
    quiet(15, "R3");

    // R7 masked expiry counts a miss
    wr(2'd2, 32'h0001_0045);
    wr(2'd0, 32'd2);
    quiet(3, "R7");
    exp_miss++;
    chk(miss_count == exp_miss, "R7", miss_count, exp_miss);
    // R7 pending vector counts a miss
    vec_pending = 1'b1;
    wr(2'd2, 32'h0000_0045);
    wr(2'd0, 32'd2);
    quiet(3, "R7");
    exp_miss++;
    chk(miss_count == exp_miss, "R7", miss_count, exp_miss);
    vec_pending = 1'b0;
    // R7 saturation: masked, periodic, expiry every cycle
    wr(2'd2, 32'h0003_0045);
    wr(2'd0, 32'd1);
    quiet(300, "R7");
    wr(2'd0, 32'd0);
    chk(miss_count == 8'hFF, "R7", miss_count, 8'hFF);

    // R11 zero start value stops the timer
    wr(2'd2, 32'h0000_0046);
    wr(2'd0, 32'd0);
    chk(cur_count == 0, "R11", cur_count, 0);
    quiet(20, "R11");
    chk(cur_count == 0, "R11", cur_count, 0);

    // R12 current-count writes ignored
    wr(2'd3, 32'h0000_1234);
    chk(cur_count == 0, "R12", cur_count, 0);
    quiet(5, "R12");
    wr(2'd1, 32'h0000_000A);
    wr(2'd0, 32'd5);
    wr(2'd3, 32'h0000_0099);
    chk(cur_count == 5, "R12", cur_count, 5);
    wr(2'd0, 32'd0);

    // R8 entry write mask, R10 no error for legal vector
    wr(2'd2, 32'hFFFF_FFFF);
    chk(tmr_entry == 32'h0003_10FF, "R8", tmr_entry, 32'h0003_10FF);
    chk(err_status == 8'h00, "R10", err_status, 0);
    // R9 software disable forces mask
    sw_disable = 1'b1;
    wr(2'd2, 32'h0000_0020);
    chk(tmr_entry == 32'h0001_0020, "R9", tmr_entry, 32'h0001_0020);
    // R10 illegal vector flags bit 6
    wr(2'd2, 32'h0000_0005);
    chk(err_status == 8'h40, "R10", err_status, 8'h40);
    sw_disable = 1'b0;
    wr(2'd2, 32'h0000_0030);
    chk(err_status == 8'h40, "R10", err_status, 8'h40);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule